// File: doc/BRIEF.md
# Strided Tile Address Streamer

This block drives one local on-chip memory of a pipelined accelerator fabric. It walks a two-level iteration space and issues one memory address per clock cycle. The inner loop covers a run of consecutive words. The outer loop repeats that run a programmed number of times, and each repetition moves the row base by a fixed step. In read mode the word at each address comes out on a 32-bit stream one cycle later, with a valid flag. In write mode the word on the input port is stored at the address issued in that cycle.

The four iteration parameters and the transfer direction are loaded once, while the block is idle. A start pulse then launches one tile. An external DMA synchronizer supplies a single gating flag. In read mode it means "the buffer holds data", and in write mode it means "the buffer has room". While this flag is low the walk pauses in place. When the last address of the tile has been issued, the block raises a sticky done flag and pulses a read commit or a write commit, so the synchronizer can hand the buffer over.

Top module: `tile_addr_stream`

## Requirements
- R1: `cfg_load` captures base, run, reps, step and direction only while `busy` is low; a `cfg_load` while `busy` is high has no effect on the addresses of the tile in flight.
- R2: The address for outer index o and inner index i is base + o*step + i, modulo 2^ADDR_W. Addresses are issued in inner-fastest order, with i in 0..run-1 and o in 0..reps-1. For example, base 6, run 3, reps 3 and step 5 give 6,7,8,11,12,13,16,17,18.
- R3: While `xfer_ok` stays high during a tile, `addr_valid` is high in every cycle, and each cycle presents the next address of the sequence.
- R4: While `xfer_ok` is low, `addr_valid` is low. The walk then resumes at the same address it had reached, with none skipped or repeated.
- R5: In read mode (`cfg_write`=0), `rd_valid` is high one cycle after each issued address, and `rd_data` then holds the memory word at that address. `rd_valid` stays low in write mode.
- R6: In write mode (`cfg_write`=1), `wr_data` is stored at `addr` on each cycle in which `addr_valid` is high.
- R7: In the cycle after the last address is issued, `busy` falls and `done` rises. `done` stays high until the next accepted start.
- R8: Together with the rise of `done`, exactly one of `rd_commit` (read mode) or `wr_commit` (write mode) is high, for a single cycle.
- R9: A `start` while `busy` is high is ignored.
- R10: A start with run or reps equal to zero raises `done` in the next cycle. It issues no address and pulses no commit.
- R11: After reset, `busy`, `done`, `addr_valid`, `rd_valid` and both commits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Capture configuration (idle only) |
| cfg_base | input | ADDR_W | First address of the tile |
| cfg_run | input | RUN_W | Words per inner run |
| cfg_reps | input | REP_W | Number of runs |
| cfg_step | input | ADDR_W | Base increment between runs |
| cfg_write | input | 1 | 1 = write tile, 0 = read tile |
| start | input | 1 | Launch one tile |
| xfer_ok | input | 1 | Not-empty (read) / not-full (write) gate |
| wr_data | input | DATA_W | Word stored in write mode |
| addr | output | ADDR_W | Current memory address |
| addr_valid | output | 1 | Address issued this cycle |
| rd_data | output | DATA_W | Word read for the previous address |
| rd_valid | output | 1 | `rd_data` is valid |
| busy | output | 1 | Tile in progress |
| done | output | 1 | Last tile finished |
| rd_commit | output | 1 | One-cycle read-tile commit |
| wr_commit | output | 1 | One-cycle write-tile commit |

## Verification
Each configuration in the table is first written and then read back. The table holds the example tile and a single-word run repeated with a step. It also holds a single run, a tile whose addresses wrap past the top of memory, and a zero step that revisits the same words. Together these separate a wrong inner/outer ordering, a missing or misapplied step, and broken modular wrap. Some table rows hold the gate low in a fixed pattern while others never stall, which shows whether a stall drops, repeats or skips an address. Directed cases cover reset, zero-sized tiles, and configuration or start pulses issued mid-tile.

// File: rtl/tile_addr_stream.sv
module tile_addr_stream #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int RUN_W  = 8,
  parameter int REP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [RUN_W-1:0]  cfg_run,
  input  logic [REP_W-1:0]  cfg_reps,
  input  logic [ADDR_W-1:0] cfg_step,
  input  logic              cfg_write,
  input  logic              start,
  input  logic              xfer_ok,
  input  logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] addr,
  output logic              addr_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              busy,
  output logic              done,
  output logic              rd_commit,
  output logic              wr_commit
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] base_q, step_q, row_q;
  logic [RUN_W-1:0]  run_q, inner_q;
  logic [REP_W-1:0]  reps_q, outer_q;
  logic              write_q;
  logic [DATA_W-1:0] mem [DEPTH];

  logic run_end, tile_end, empty_cfg;

  assign addr       = row_q + ADDR_W'(inner_q);
  assign addr_valid = busy & xfer_ok;
  assign run_end    = inner_q == run_q - RUN_W'(1);
  assign tile_end   = run_end && (outer_q == reps_q - REP_W'(1));
  assign empty_cfg  = (run_q == '0) || (reps_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q    <= '0;
      step_q    <= '0;
      run_q     <= '0;
      reps_q    <= '0;
      write_q   <= 1'b0;
      row_q     <= '0;
      inner_q   <= '0;
      outer_q   <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      rd_commit <= 1'b0;
      wr_commit <= 1'b0;
      rd_valid  <= 1'b0;
    end else begin
      rd_commit <= 1'b0;
      wr_commit <= 1'b0;
      rd_valid  <= addr_valid & ~write_q;
      if (cfg_load && !busy) begin
        base_q  <= cfg_base;
        step_q  <= cfg_step;
        run_q   <= cfg_run;
        reps_q  <= cfg_reps;
        write_q <= cfg_write;
      end
      if (start && !busy) begin
        row_q   <= base_q;
        inner_q <= '0;
        outer_q <= '0;
        done    <= empty_cfg;
        busy    <= ~empty_cfg;
      end else if (addr_valid) begin
        if (tile_end) begin
          busy      <= 1'b0;
          done      <= 1'b1;
          rd_commit <= ~write_q;
          wr_commit <= write_q;
        end else if (run_end) begin
          inner_q <= '0;
          outer_q <= outer_q + REP_W'(1);
          row_q   <= row_q + step_q;
        end else begin
          inner_q <= inner_q + RUN_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (addr_valid && write_q) mem[addr] <= wr_data;
    if (addr_valid && !write_q) rd_data <= mem[addr];
  end

  p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !xfer_ok && !start) |=> (busy && $stable(addr)));

  p_rd_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(addr_valid && !write_q));

  p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !addr_valid));

  p_commit_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_commit || wr_commit) |=> !(rd_commit || wr_commit));

  p_commit_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_commit || wr_commit) |-> (done && !(rd_commit && wr_commit)));

  p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && xfer_ok && !tile_end) |=> busy);
endmodule

// File: tb/tile_addr_stream_tb.sv
module tile_addr_stream_tb;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int NV = 5;
  localparam int V_BASE [NV] = '{6, 40, 100, 200, 10};
  localparam int V_RUN  [NV] = '{3, 1, 5, 4, 2};
  localparam int V_REPS [NV] = '{3, 4, 1, 3, 2};
  localparam int V_STEP [NV] = '{5, 10, 0, 30, 0};
  localparam logic [7:0] V_GATE [NV] = '{8'hFF, 8'b1011_0110, 8'hFF, 8'b1110_1101, 8'b0101_1111};

  logic clk = 0, rst_n = 0;
  logic cfg_load = 0, cfg_write = 0, start = 0, xfer_ok = 0;
  logic [ADDR_W-1:0] cfg_base = 0, cfg_step = 0;
  logic [7:0] cfg_run = 0, cfg_reps = 0;
  logic [DATA_W-1:0] wr_data = 0;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] rd_data;
  logic addr_valid, rd_valid, busy, done, rd_commit, wr_commit;

  int checks = 0, errors = 0, cyc = 0;

  tile_addr_stream u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_base(cfg_base),
    .cfg_run(cfg_run), .cfg_reps(cfg_reps), .cfg_step(cfg_step),
    .cfg_write(cfg_write), .start(start), .xfer_ok(xfer_ok), .wr_data(wr_data),
    .addr(addr), .addr_valid(addr_valid), .rd_data(rd_data), .rd_valid(rd_valid),
    .busy(busy), .done(done), .rd_commit(rd_commit), .wr_commit(wr_commit));

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 60000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 60000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [DATA_W-1:0] pat(input logic [ADDR_W-1:0] a);
    return 32'hC3A5_0000 ^ ({24'd0, a} * 32'h0101_0101);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic load_cfg(input int b, input int r, input int n, input int s, input bit w);
    @(negedge clk);
    cfg_base = ADDR_W'(b); cfg_run = 8'(r); cfg_reps = 8'(n);
    cfg_step = ADDR_W'(s); cfg_write = w; cfg_load = 1;
    @(negedge clk);
    cfg_load = 0;
  endtask

  task automatic run_tile(input int v, input bit w);
    logic [ADDR_W-1:0] exp_a [256];
    int total, idx, k;
    bit prev_iss;
    logic [ADDR_W-1:0] prev_a;
    total = 0;
    for (int o = 0; o < V_REPS[v]; o++)
      for (int i = 0; i < V_RUN[v]; i++) begin
        exp_a[total] = ADDR_W'(V_BASE[v] + o * V_STEP[v] + i);
        total++;
      end
    load_cfg(V_BASE[v], V_RUN[v], V_REPS[v], V_STEP[v], w);
    start = 1;
    @(negedge clk);
    start = 0;
    idx = 0; k = 0; prev_iss = 0; prev_a = '0;
    forever begin
      xfer_ok = V_GATE[v][k % 8];
      cfg_load = 0; start = 0;
      #1;
      if (!w && prev_iss)
        chk(rd_valid && rd_data == pat(prev_a), "R5", "read word", rd_data, pat(prev_a));
      else
        chk(!rd_valid, "R5", "rd_valid idle", 32'(rd_valid), 0);
      if (idx == total) begin
        chk(done && !busy, "R7", "done/busy at end", {30'd0, done, busy}, 32'h2);
        chk(rd_commit == !w && wr_commit == w, "R8", "commit kind",
            {30'd0, rd_commit, wr_commit}, {30'd0, !w, w});
        break;
      end
      if (xfer_ok) begin
        chk(addr_valid && addr == exp_a[idx], w ? "R2 R3 R6" : "R2 R3", "address", addr, exp_a[idx]);
        wr_data = pat(exp_a[idx]);
        prev_a = exp_a[idx];
        prev_iss = 1;
        idx++;
        if (idx == 2 && total > 3) begin
          cfg_load = 1; cfg_run = 8'd1; cfg_reps = 8'd1; cfg_step = 8'd77; // R1
          start = 1; // R9
        end
      end else begin
        chk(!addr_valid, "R4", "stall gate", 32'(addr_valid), 0);
        prev_iss = 0;
      end
      k++;
      @(negedge clk);
      cfg_load = 0; start = 0;
      #0;
    end
    @(negedge clk);
    #1;
    chk(!rd_commit && !wr_commit && done, "R8", "commit single cycle",
        {30'd0, rd_commit, wr_commit}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !done && !addr_valid && !rd_valid && !rd_commit && !wr_commit,
        "R11", "reset outputs", {26'd0, busy, done, addr_valid, rd_valid, rd_commit, wr_commit}, 0);
    rst_n = 1;

    for (int v = 0; v < NV; v++) begin
      run_tile(v, 1'b1);
      run_tile(v, 1'b0);
    end

    // R10: zero run and zero reps
    for (int z = 0; z < 2; z++) begin
      load_cfg(50, z == 0 ? 0 : 3, z == 0 ? 2 : 0, 1, 1'b0);
      xfer_ok = 1; start = 1;
      @(negedge clk);
      start = 0;
      #1;
      chk(done && !busy && !addr_valid && !rd_commit && !wr_commit, "R10", "empty tile",
          {28'd0, done, busy, rd_commit, wr_commit}, 32'h8);
    end

    // R7: done clears on next accepted start
    load_cfg(0, 2, 1, 0, 1'b0);
    xfer_ok = 0; start = 1;
    @(negedge clk);
    start = 0;
    #1;
    chk(!done && busy, "R7", "done cleared by start", {30'd0, done, busy}, 32'h1);
    xfer_ok = 1;
    repeat (3) @(negedge clk);
    xfer_ok = 0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule